// File: doc/BRIEF.md
# Subvector Element Swizzle Engine

This block rearranges short vectors held in a byte-addressed register file. The source region is seen as a run of groups, each holding a fixed number of elements (the source group length). The destination region is seen the same way, with its own group length. For every group, each destination lane copies one lane of the matching source group. The lane it copies is chosen by a constant selector that comes with the command. A lane may be chosen more than once, so a three-element group can become a four-element group. With a destination length of one, the block pulls a single chosen element out of every source group.

A command is a one-cycle start pulse that carries these values: the group count, both group lengths, the element width, the selector list and the two base registers. The engine then performs one read and one write per destination element, one element per cycle, on a read/write port pair of the register file. It ends with a one-cycle done pulse. A command whose configuration cannot be carried out raises an illegal flag together with done and writes nothing.

Top module: `swz_engine`

## Requirements
- R1: For group i (0 to count-1) and destination lane j (0 to dst_len-1), destination element i*dst_len+j receives a copy of source element i*src_len+sel[j]. Selector j occupies bits [2j+1:2j] of `sel`.
- R2: A legal command with count N>0 performs exactly N*dst_len writes, one per cycle, in ascending destination index order. `busy` is high in exactly those cycles. `done` is high for one cycle, N*dst_len+1 cycles after the start edge.
- R3: A command with count 0 writes nothing and raises `done` in the cycle right after the start edge.
- R4: With dst_len 1 and a single selector k, destination element i is source element i*src_len+k.
- R5: Selectors may repeat a source lane, and the repeated lanes each receive the same source value.
- R6: `el_type` encodes the element width: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits. Element n of a region that starts at register b sits at byte address b*8 + n*bytes, modulo the address space, and is stored little-endian.
- R7: If any selector of a lane below dst_len is greater than or equal to src_len, the engine raises `illegal` together with `done` one cycle after start and writes nothing. Selectors of lanes at or above dst_len are ignored.
- R8: A group length outside 1..4, an `el_type` of 3, or a count above 64 is rejected in the same way as in R7.
- R9: A start pulse that arrives while `busy` is high is ignored, and so are the configuration values present with it. The command already running completes exactly as it was issued.
- R10: Within a cycle the read returns the contents as they were before that cycle's write. Elements are processed strictly in order, so a destination that overlaps the source gives the same result as copying one element at a time.
- R11: Each write changes only the bytes of its own element. All other bytes of the register file keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, sampled when idle |
| vl | input | 7 | Number of groups (0..64) |
| src_len | input | 3 | Source group length (1..4) |
| dst_len | input | 3 | Destination group length (1..4) |
| el_type | input | 2 | Element width code |
| sel | input | 8 | Packed lane selectors, 2 bits per lane |
| src_reg | input | 7 | Base register of the source region |
| dst_reg | input | 7 | Base register of the destination region |
| busy | output | 1 | Element transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Rejected command, high together with done |
| rf_ren | output | 1 | Register file read enable |
| rf_raddr | output | 10 | Read byte address |
| rf_rdata | input | 32 | Read data, little-endian from rf_raddr |
| rf_wen | output | 1 | Register file write enable |
| rf_waddr | output | 10 | Write byte address |
| rf_wsize | output | 2 | Write width, same code as el_type |
| rf_wdata | output | 32 | Write data, element in the low bits |

## Verification
The hardest case to reach is a second start that arrives in the middle of a transfer. It comes with a configuration that would be meaningful if it were accepted. The bench drives it two cycles into a multi-group run, with a count of zero and different selectors, and then checks that the final memory image, the write count and the done latency all match the first command. The in-place case is also hard to reach, because read-before-write order only shows when source and destination overlap. The bench runs an extraction with both bases equal and compares the result against a reference model that copies one element at a time.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    EL_B8  = 2'd0,
    EL_B16 = 2'd1,
    EL_B32 = 2'd2,
    EL_BAD = 2'd3
  } el_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  function automatic logic [2:0] el_bytes(el_e t);
    case (t)
      EL_B8:   return 3'd1;
      EL_B16:  return 3'd2;
      EL_B32:  return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] el_mask(el_e t);
    case (t)
      EL_B8:   return 32'h0000_00FF;
      EL_B16:  return 32'h0000_FFFF;
      EL_B32:  return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  // byte address = register base * 8 + element index * element bytes
  function automatic logic [31:0] elem_addr(logic [31:0] base, logic [31:0] idx, el_e t);
    return (base << 3) + idx * {29'd0, el_bytes(t)};
  endfunction

endpackage

// File: rtl/swz_cfg_check.sv
module swz_cfg_check #(
  parameter int MAXSUB = 4,
  parameter int MAXVL  = 64,
  parameter int SUB_W  = 3,
  parameter int SEL_W  = 2,
  parameter int VL_W   = 7
) (
  input  logic [VL_W-1:0]         vl,
  input  logic [SUB_W-1:0]        src_len,
  input  logic [SUB_W-1:0]        dst_len,
  input  logic [1:0]              el_type,
  input  logic [MAXSUB*SEL_W-1:0] sel,
  output logic                    bad
);
  logic [MAXSUB-1:0] lane_bad;

  for (genvar j = 0; j < MAXSUB; j++) begin : g_lane
    logic [SEL_W-1:0] s;
    assign s = sel[j*SEL_W +: SEL_W];
    assign lane_bad[j] = (SUB_W'(j) < dst_len) && (SUB_W'(s) >= src_len);
  end

  logic len_bad;
  assign len_bad = (src_len == '0) || (dst_len == '0) ||
                   (src_len > SUB_W'(MAXSUB)) || (dst_len > SUB_W'(MAXSUB));

  assign bad = (|lane_bad) || len_bad || (el_type == 2'd3) || (vl > VL_W'(MAXVL));
endmodule

// File: rtl/swz_walker.sv
module swz_walker #(
  parameter int VL_W  = 7,
  parameter int SUB_W = 3,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [VL_W-1:0]  vl,
  input  logic [SUB_W-1:0] src_len,
  input  logic [SUB_W-1:0] dst_len,
  output logic [SUB_W-1:0] lane,
  output logic [IDX_W-1:0] src_grp_base,
  output logic [IDX_W-1:0] dst_idx,
  output logic             last
);
  logic [VL_W-1:0] grp;
  logic            lane_end;

  assign lane_end = (lane == dst_len - SUB_W'(1));
  assign last     = lane_end && (grp == vl - VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0; lane <= '0; src_grp_base <= '0; dst_idx <= '0;
    end else if (load) begin
      grp <= '0; lane <= '0; src_grp_base <= '0; dst_idx <= '0;
    end else if (step) begin
      dst_idx <= dst_idx + IDX_W'(1);
      if (lane_end) begin
        lane         <= '0;
        grp          <= grp + VL_W'(1);
        src_grp_base <= src_grp_base + IDX_W'(src_len);
      end else begin
        lane <= lane + SUB_W'(1);
      end
    end
  end
endmodule

// File: rtl/swz_engine.sv
module swz_engine #(
  parameter int NREG   = 128,
  parameter int MAXVL  = 64,
  parameter int MAXSUB = 4,
  parameter int EW     = 32,
  localparam int VL_W   = $clog2(MAXVL + 1),
  localparam int SUB_W  = $clog2(MAXSUB + 1),
  localparam int SEL_W  = $clog2(MAXSUB),
  localparam int RB_W   = $clog2(NREG),
  localparam int ADDR_W = $clog2(NREG * 8)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [VL_W-1:0]         vl,
  input  logic [SUB_W-1:0]        src_len,
  input  logic [SUB_W-1:0]        dst_len,
  input  logic [1:0]              el_type,
  input  logic [MAXSUB*SEL_W-1:0] sel,
  input  logic [RB_W-1:0]         src_reg,
  input  logic [RB_W-1:0]         dst_reg,
  output logic                    busy,
  output logic                    done,
  output logic                    illegal,
  output logic                    rf_ren,
  output logic [ADDR_W-1:0]       rf_raddr,
  input  logic [EW-1:0]           rf_rdata,
  output logic                    rf_wen,
  output logic [ADDR_W-1:0]       rf_waddr,
  output logic [1:0]              rf_wsize,
  output logic [EW-1:0]           rf_wdata
);
  import swz_pkg::*;

  localparam int IDX_W = $clog2(MAXVL * MAXSUB);

  st_e                    state;
  logic [VL_W-1:0]        vl_q;
  logic [SUB_W-1:0]       src_len_q, dst_len_q;
  el_e                    el_q;
  logic [MAXSUB*SEL_W-1:0] sel_q;
  logic [RB_W-1:0]        src_reg_q, dst_reg_q;
  logic                   ill_q;

  // named internal events for the checker
  logic accept, cfg_bad, walk_step, walk_last;
  logic [SUB_W-1:0] lane;
  logic [IDX_W-1:0] src_grp_base, dst_idx, src_idx;

  assign accept    = start && (state == ST_IDLE);
  assign walk_step = (state == ST_RUN);

  swz_cfg_check #(.MAXSUB(MAXSUB), .MAXVL(MAXVL), .SUB_W(SUB_W), .SEL_W(SEL_W), .VL_W(VL_W))
    u_cfg (.vl(vl), .src_len(src_len), .dst_len(dst_len), .el_type(el_type), .sel(sel), .bad(cfg_bad));

  swz_walker #(.VL_W(VL_W), .SUB_W(SUB_W), .IDX_W(IDX_W))
    u_walk (.clk(clk), .rst_n(rst_n), .load(accept), .step(walk_step),
            .vl(vl_q), .src_len(src_len_q), .dst_len(dst_len_q),
            .lane(lane), .src_grp_base(src_grp_base), .dst_idx(dst_idx), .last(walk_last));

  logic [SEL_W-1:0] sel_arr [MAXSUB];
  for (genvar j = 0; j < MAXSUB; j++) begin : g_sel
    assign sel_arr[j] = sel_q[j*SEL_W +: SEL_W];
  end

  assign src_idx = src_grp_base + IDX_W'(sel_arr[lane[SEL_W-1:0]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      vl_q <= '0; src_len_q <= '0; dst_len_q <= '0; el_q <= EL_B8;
      sel_q <= '0; src_reg_q <= '0; dst_reg_q <= '0; ill_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          vl_q <= vl; src_len_q <= src_len; dst_len_q <= dst_len;
          el_q <= el_e'(el_type); sel_q <= sel;
          src_reg_q <= src_reg; dst_reg_q <= dst_reg;
          ill_q <= cfg_bad;
          state <= (cfg_bad || vl == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN:  if (walk_last) state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state == ST_RUN);
  assign done    = (state == ST_FIN);
  assign illegal = done && ill_q;

  assign rf_ren   = walk_step;
  assign rf_wen   = walk_step;
  assign rf_raddr = ADDR_W'(elem_addr(32'(src_reg_q), 32'(src_idx), el_q));
  assign rf_waddr = ADDR_W'(elem_addr(32'(dst_reg_q), 32'(dst_idx), el_q));
  assign rf_wsize = el_q;
  assign rf_wdata = rf_rdata & EW'(el_mask(el_q));
endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int VL_W   = 7,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [VL_W-1:0]   vl,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              rf_wen,
  input logic [1:0]        rf_wsize,
  input logic [ADDR_W-1:0] rf_waddr,
  input logic              accept,
  input logic              cfg_bad,
  input logic              walk_last
);
  p_write_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wen |-> busy);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_empty_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vl == '0) |=> (done && !busy));

  p_reject_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_bad) |=> (illegal && !rf_wen));

  p_legal_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_bad) |=> !illegal);

  p_illegal_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !walk_last) |=> busy);

  p_aligned_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wen && rf_wsize == 2'd2) |-> (rf_waddr[1:0] == 2'b00));
endmodule

bind swz_engine swz_checker #(.VL_W(VL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .busy(busy), .done(done),
  .illegal(illegal), .rf_wen(rf_wen), .rf_wsize(rf_wsize), .rf_waddr(rf_waddr),
  .accept(accept), .cfg_bad(cfg_bad), .walk_last(walk_last)
);

// File: tb/tb_swz_engine.sv
`timescale 1ns/1ps
module tb_swz_engine;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [6:0] vl_i = '0;
  logic [2:0] sl_i = 3'd1, dl_i = 3'd1;
  logic [1:0] et_i = '0;
  logic [7:0] sel_i = '0;
  logic [6:0] sb_i = '0, db_i = '0;
  logic busy, done, illegal, rf_ren, rf_wen;
  logic [9:0] rf_raddr, rf_waddr;
  logic [1:0] rf_wsize;
  logic [31:0] rf_rdata, rf_wdata;

  int checks = 0, errors = 0, wcount = 0;
  logic [7:0] mem   [1024];
  logic [7:0] ref_m [1024];

  always #10 clk = ~clk;

  swz_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl_i), .src_len(sl_i), .dst_len(dl_i),
    .el_type(et_i), .sel(sel_i), .src_reg(sb_i), .dst_reg(db_i),
    .busy(busy), .done(done), .illegal(illegal),
    .rf_ren(rf_ren), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_wen(rf_wen), .rf_waddr(rf_waddr), .rf_wsize(rf_wsize), .rf_wdata(rf_wdata));

  assign rf_rdata = {mem[rf_raddr + 10'd3], mem[rf_raddr + 10'd2], mem[rf_raddr + 10'd1], mem[rf_raddr]};

  always @(posedge clk)
    if (rf_wen)
      for (int k = 0; k < 4; k++)
        if (k < (1 << rf_wsize)) mem[rf_waddr + 10'(k)] <= rf_wdata[8*k +: 8];

  always @(negedge clk) if (rf_wen) wcount++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // element-at-a-time reference copy, following the requirement formulas
  task automatic model(int sb, int db, int n, int s, int d, int t, logic [7:0] sel);
    int nb = 1 << t;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < d; j++) begin
        int si = i * s + int'(sel[2*j +: 2]);
        int di = i * d + j;
        int sa = (sb * 8 + si * nb) % 1024;
        int da = (db * 8 + di * nb) % 1024;
        logic [7:0] tmp [4];
        for (int k = 0; k < nb; k++) tmp[k] = ref_m[(sa + k) % 1024];
        for (int k = 0; k < nb; k++) ref_m[(da + k) % 1024] = tmp[k];
      end
  endtask

  task automatic run_case(string req, int sb, int db, int n, int s, int d, int t,
                          logic [7:0] sel, bit exp_ill, bit poke);
    int cyc = 0, diff = 0, exp_w;
    for (int k = 0; k < 1024; k++) ref_m[k] = mem[k];
    if (!exp_ill) model(sb, db, n, s, d, t, sel);
    exp_w = exp_ill ? 0 : n * d;
    @(negedge clk);
    wcount = 0;
    vl_i = 7'(n); sl_i = 3'(s); dl_i = 3'(d); et_i = 2'(t); sel_i = sel;
    sb_i = 7'(sb); db_i = 7'(db); start = 1'b1;
    @(negedge clk); start = 1'b0; cyc = 1;
    while (!done && cyc < 3000) begin
      if (poke && cyc == 2) begin start = 1'b1; vl_i = '0; sel_i = 8'hFF; sl_i = 3'd1; end
      else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    check({req, " done latency"}, cyc, exp_ill ? 1 : n * d + 1);
    check({req, " illegal flag"}, int'(illegal), int'(exp_ill));
    check({req, " write count"}, wcount, exp_w);
    check({req, " busy after done"}, int'(busy), 0);
    @(negedge clk);
    for (int k = 0; k < 1024; k++) if (mem[k] !== ref_m[k]) diff++;
    check({req, " R11 mismatching bytes"}, diff, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 8'((k * 37 + 11) ^ (k >> 3));
    repeat (3) @(negedge clk);
    check("R2 reset busy", int'(busy), 0);
    check("R2 reset done", int'(done), 0);
    check("R7 reset illegal", int'(illegal), 0);
    check("R2 reset write", int'(rf_wen), 0);
    rst_n = 1'b1;
    // R1 R5: 3 -> 4 lanes with a repeated lane, bytes
    run_case("R1 R5 widen u8", 48, 32, 5, 3, 4, 0, {2'd1, 2'd2, 2'd0, 2'd0}, 1'b0, 1'b0);
    // R4 R6: pull lane 2 out of 4-wide 32-bit groups
    run_case("R4 R6 extract u32", 64, 8, 5, 4, 1, 2, {2'd0, 2'd0, 2'd0, 2'd2}, 1'b0, 1'b0);
    // R1 R6: 16-bit, 2 -> 3 lanes
    run_case("R1 R6 u16", 20, 90, 7, 2, 3, 1, {2'd0, 2'd1, 2'd0, 2'd1}, 1'b0, 1'b0);
    // R3: empty command
    run_case("R3 zero count", 10, 12, 0, 2, 2, 0, 8'h00, 1'b0, 1'b0);
    // R7: selector 3 with source length 3
    run_case("R7 bad selector", 10, 12, 4, 3, 4, 0, {2'd3, 2'd0, 2'd1, 2'd2}, 1'b1, 1'b0);
    // R7: unused lanes carry out-of-range selectors, still legal
    run_case("R7 unused lanes", 30, 40, 3, 2, 2, 1, {2'd3, 2'd3, 2'd0, 2'd1}, 1'b0, 1'b0);
    // R8: bad lengths, width code and count
    run_case("R8 zero length", 10, 12, 2, 0, 2, 0, 8'h00, 1'b1, 1'b0);
    run_case("R8 width code", 10, 12, 2, 2, 2, 3, 8'h00, 1'b1, 1'b0);
    run_case("R8 count 65", 10, 12, 65, 1, 1, 0, 8'h00, 1'b1, 1'b0);
    // R9: second start mid-run
    run_case("R9 start while busy", 100, 70, 4, 4, 4, 0, {2'd0, 2'd1, 2'd2, 2'd3}, 1'b0, 1'b1);
    // R10: in place extraction
    run_case("R10 in place", 50, 50, 6, 3, 1, 1, {2'd0, 2'd0, 2'd0, 2'd2}, 1'b0, 1'b0);
    // R2: longest count
    run_case("R2 full count", 64, 0, 64, 1, 1, 0, 8'h00, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule